// File: doc/BRIEF.md
# Linkable Instruction Breakpoint Comparator Bank

This block watches the instruction fetch stream and raises a breakpoint flag when any of six programmable comparator pairs fires. Each pair holds a 32-bit value and a control word. A pair compares its value either with the word address of the fetch or with the 32-bit context ID of the running thread. An address pair can be tied to a context pair, so that the two must agree in the same cycle. This lets a debugger stop one thread without stopping every thread that shares the code.

An address pair can also run in inverted (mismatch) mode. In that mode it fires on every fetch except the one at the programmed location, which is how a debugger single-steps. Each pair can also be limited to one security world and to one privilege level.

Software writes new settings into a staging copy. The staging copy moves into the active copy on an instruction-barrier strobe. The per-pair hit vector and the combined flag are registered, so they appear one cycle after the qualifying fetch.

Top module: `bkpt_unit`

## Requirements
- R1: After reset every pair is disabled and both outputs are 0. Until the first barrier no fetch can raise a hit.
- R2: In mode 000 (control bits 22:20), an enabled pair fires when value bits 31:2 equal fetch address bits 31:2 and at least one byte is set in both select bits 8:5 and `fetch_lanes`. Bit 5 and lane bit 0 are byte 0, and bit 8 is byte 3. A zero select never fires.
- R3: In mode 100, an enabled pair with a nonzero byte select fires on every fetch that does not meet the R2 match.
- R4: World bits 15:14 gate a pair: 00 either world, 01 non-secure only, 10 secure only, 11 never. Privilege bits 2:1 gate a pair: 11 either level, 01 privileged only, 10 user only, 00 never. Enable is control bit 0.
- R5: Pairs 4 and 5 in mode 010 fire when their full 32-bit value equals `ctx_id`, whatever the fetch address and byte select.
- R6: Modes 001 and 101 add the R2 or R3 address term to a link term. The link term holds when the pair numbered in bits 19:16 is enabled, is in mode 011 and matches `ctx_id` in the same cycle. Only the address pair's world and privilege fields apply. Several pairs may share one target.
- R7: A link fails, and so gives no hit, when it names the pair itself, a number of 6 or more, a pair below 4, or a pair that is not in mode 011.
- R8: A pair in mode 011, 110 or 111 never sets its own hit bit.
- R9: When `priv_mode` and `monitor_mode` are both 1, hits from modes 010, 100 and 101 are dropped. Modes 000 and 001 still fire.
- R10: Pairs 0 to 3 store control bit 21 as 0, so a write of mode 010 to one of them acts as mode 000.
- R11: Writes reach the staging copy only. A barrier copies staging to active. A fetch in the barrier cycle is judged against the settings in force before it.
- R12: `bp_hit_vec` shows, one cycle later, the per-pair result of a fetch with `fetch_valid` = 1, and 0 when `fetch_valid` was 0. `bp_hit` is the OR of the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetch strobe |
| fetch_addr | input | 32 | Fetch address |
| fetch_lanes | input | 4 | Bytes of the word accessed, bit n = byte n |
| priv_mode | input | 1 | 1 = privileged access |
| secure | input | 1 | 1 = secure world |
| monitor_mode | input | 1 | 1 = monitor debug mode selected |
| ctx_id | input | 32 | Current context ID |
| wr_val_en | input | 1 | Write strobe for a value word |
| wr_ctl_en | input | 1 | Write strobe for a control word |
| wr_idx | input | 3 | Pair selected for the write |
| wr_data | input | 32 | Write data |
| barrier | input | 1 | Instruction barrier, commits staged settings |
| bp_hit | output | 1 | Any pair hit |
| bp_hit_vec | output | 6 | Per-pair hit |

## Verification
A barrier and a fetch can fall in the same cycle. The bench drives both on one edge right after staging a new breakpoint, and expects the old settings to decide that fetch and the new ones to decide the next.

A linked address match and the privileged-monitor suppression can also meet in one cycle. A near-exhaustive sweep over mode, world, privilege and link fields provokes this. A reference model computed from the requirements judges each fetch.

// File: rtl/bkpt_pkg.sv
// Shared types and helpers for the breakpoint comparator bank.
// Assumes control-word field positions as listed in the brief.
package bkpt_pkg;
    localparam int unsigned DEF_NUM_PAIRS = 6;
    localparam int unsigned DEF_CTX_FIRST = 4;

    localparam logic [2:0] MD_ADDR     = 3'b000;
    localparam logic [2:0] MD_ADDR_LNK = 3'b001;
    localparam logic [2:0] MD_CTX      = 3'b010;
    localparam logic [2:0] MD_CTX_TGT  = 3'b011;
    localparam logic [2:0] MD_MIS      = 3'b100;
    localparam logic [2:0] MD_MIS_LNK  = 3'b101;

    // Decoded control word, only the meaningful fields are stored.
    typedef struct packed {
        logic [2:0] mode;
        logic [3:0] link;
        logic [1:0] world;
        logic [3:0] lanes;
        logic [1:0] level;
        logic       en;
    } bp_ctl_t;

    // World gate: 00 any, 01 non-secure, 10 secure, 11 never.
    function automatic logic world_ok(input logic [1:0] sel, input logic sec);
        return (sel == 2'b00) || (sel == 2'b01 && !sec) || (sel == 2'b10 && sec);
    endfunction

    // Privilege gate: 11 any, 01 privileged, 10 user, 00 never.
    function automatic logic level_ok(input logic [1:0] sel, input logic prv);
        return (sel == 2'b11) || (sel == 2'b01 && prv) || (sel == 2'b10 && !prv);
    endfunction
endpackage

// File: rtl/bkpt_regs.sv
// Staging and active copies of each pair's value and control word.
// Writes land in staging; a barrier copies staging into the active copy.
// Assumes pairs numbered CTX_FIRST and above can compare a context ID.
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = DEF_NUM_PAIRS,
    parameter int unsigned CTX_FIRST = DEF_CTX_FIRST,
    parameter int unsigned IDX_W     = $clog2(NUM_PAIRS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_val_en,
    input  logic                        wr_ctl_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [31:0]                 wr_data,
    input  logic                        barrier,
    output logic [NUM_PAIRS-1:0][31:0]  live_val,
    output bp_ctl_t [NUM_PAIRS-1:0]     live_ctl
);
    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[31:23], wr_data[13:9], wr_data[4:3]};

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        localparam bit CTX_CAP = (i >= CTX_FIRST);
        logic [31:0] stage_val;
        bp_ctl_t     stage_ctl;
        bp_ctl_t     wr_ctl;
        logic        sel;

        assign sel = (wr_idx == IDX_W'(i));

        // Decode the write word into fields; bit 21 kept only on context-capable pairs.
        always_comb begin
            wr_ctl.mode  = {wr_data[22], CTX_CAP ? wr_data[21] : 1'b0, wr_data[20]};
            wr_ctl.link  = wr_data[19:16];
            wr_ctl.world = wr_data[15:14];
            wr_ctl.lanes = wr_data[8:5];
            wr_ctl.level = wr_data[2:1];
            wr_ctl.en    = wr_data[0];
        end

        // Capture writes into staging and commit staging on a barrier.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_val   <= '0;
                stage_ctl   <= '0;
                live_val[i] <= '0;
                live_ctl[i] <= '0;
            end else begin
                if (wr_val_en && sel) stage_val <= wr_data;
                if (wr_ctl_en && sel) stage_ctl <= wr_ctl;
                if (barrier) begin
                    live_val[i] <= stage_val;
                    live_ctl[i] <= stage_ctl;
                end
            end
        end
    end
endmodule

// File: rtl/bkpt_match.sv
// Per-pair comparators plus link resolution and mode selection.
// Purely combinational; the result is registered by the top module.
module bkpt_match
    import bkpt_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = DEF_NUM_PAIRS,
    parameter int unsigned CTX_FIRST = DEF_CTX_FIRST
) (
    input  logic [NUM_PAIRS-1:0][31:0]  live_val,
    input  bp_ctl_t [NUM_PAIRS-1:0]     live_ctl,
    input  logic [31:0]                 fetch_addr,
    input  logic [3:0]                  fetch_lanes,
    input  logic                        priv_mode,
    input  logic                        secure,
    input  logic                        monitor_mode,
    input  logic [31:0]                 ctx_id,
    output logic [NUM_PAIRS-1:0]        raw_vec
);
    logic [NUM_PAIRS-1:0] addr_eq, addr_ne, ctx_eq, gate_ok;
    logic                 suppress;
    logic                 unused_addr_lo;

    assign unused_addr_lo = ^fetch_addr[1:0];
    assign suppress       = priv_mode && monitor_mode;

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_cmp
        logic word_eq, lane_any, lanes_set;
        assign word_eq   = (live_val[i][31:2] == fetch_addr[31:2]);
        assign lane_any  = |(live_ctl[i].lanes & fetch_lanes);
        assign lanes_set = |live_ctl[i].lanes;
        assign addr_eq[i] = word_eq && lane_any;
        assign addr_ne[i] = lanes_set && !(word_eq && lane_any);
        assign gate_ok[i] = world_ok(live_ctl[i].world, secure) &&
                            level_ok(live_ctl[i].level, priv_mode);
        if (i >= CTX_FIRST) begin : g_ctx
            assign ctx_eq[i] = (live_val[i] == ctx_id);
        end else begin : g_noctx
            logic unused_val_lo;
            assign unused_val_lo = ^live_val[i][1:0];
            assign ctx_eq[i]     = 1'b0;
        end
    end

    // Resolve each pair's link and apply its mode, gates and suppression.
    always_comb begin
        for (int i = 0; i < NUM_PAIRS; i++) begin
            logic link_ok;
            logic base;
            link_ok = 1'b0;
            for (int j = CTX_FIRST; j < NUM_PAIRS; j++) begin
                if (int'(live_ctl[i].link) == j && j != i &&
                    live_ctl[j].mode == MD_CTX_TGT && live_ctl[j].en && ctx_eq[j])
                    link_ok = 1'b1;
            end
            base = live_ctl[i].en && gate_ok[i];
            case (live_ctl[i].mode)
                MD_ADDR:     raw_vec[i] = base && addr_eq[i];
                MD_ADDR_LNK: raw_vec[i] = base && addr_eq[i] && link_ok;
                MD_CTX:      raw_vec[i] = base && ctx_eq[i] && !suppress;
                MD_MIS:      raw_vec[i] = base && addr_ne[i] && !suppress;
                MD_MIS_LNK:  raw_vec[i] = base && addr_ne[i] && link_ok && !suppress;
                default:     raw_vec[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/bkpt_unit.sv
// Top of the breakpoint comparator bank: register storage, matching and
// the registered, fetch-qualified hit outputs.
// Assumes one fetch per cycle and synchronous active-low reset.
module bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = DEF_NUM_PAIRS,
    parameter int unsigned CTX_FIRST = DEF_CTX_FIRST,
    parameter int unsigned IDX_W     = $clog2(NUM_PAIRS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fetch_valid,
    input  logic [31:0]           fetch_addr,
    input  logic [3:0]            fetch_lanes,
    input  logic                  priv_mode,
    input  logic                  secure,
    input  logic                  monitor_mode,
    input  logic [31:0]           ctx_id,
    input  logic                  wr_val_en,
    input  logic                  wr_ctl_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [31:0]           wr_data,
    input  logic                  barrier,
    output logic                  bp_hit,
    output logic [NUM_PAIRS-1:0]  bp_hit_vec
);
    logic [NUM_PAIRS-1:0][31:0] live_val;
    bp_ctl_t [NUM_PAIRS-1:0]    live_ctl;
    logic [NUM_PAIRS-1:0]       raw_vec;
    logic [NUM_PAIRS-1:0]       hit_q;

    bkpt_regs #(.NUM_PAIRS(NUM_PAIRS), .CTX_FIRST(CTX_FIRST), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_val_en(wr_val_en), .wr_ctl_en(wr_ctl_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .barrier(barrier),
        .live_val(live_val), .live_ctl(live_ctl)
    );

    bkpt_match #(.NUM_PAIRS(NUM_PAIRS), .CTX_FIRST(CTX_FIRST)) u_match (
        .live_val(live_val), .live_ctl(live_ctl), .fetch_addr(fetch_addr),
        .fetch_lanes(fetch_lanes), .priv_mode(priv_mode), .secure(secure),
        .monitor_mode(monitor_mode), .ctx_id(ctx_id), .raw_vec(raw_vec)
    );

    // Register the per-pair result, cleared when no fetch is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= '0;
        else        hit_q <= fetch_valid ? raw_vec : '0;
    end

    assign bp_hit_vec = hit_q;
    assign bp_hit     = |hit_q;
endmodule

// File: rtl/bkpt_unit_chk.sv
// Assertion checker for bkpt_unit, attached by bind below.
module bkpt_unit_chk
    import bkpt_pkg::*;
#(
    parameter int unsigned NUM_PAIRS = DEF_NUM_PAIRS
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     fetch_valid,
    input logic                     barrier,
    input logic                     priv_mode,
    input logic                     monitor_mode,
    input bp_ctl_t [NUM_PAIRS-1:0]  live_ctl,
    input logic [NUM_PAIRS-1:0]     raw_vec,
    input logic [NUM_PAIRS-1:0]     bp_hit_vec
);
    logic seen_barrier;
    logic unused_fields;

    // Record whether any barrier has occurred since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       seen_barrier <= 1'b0;
        else if (barrier) seen_barrier <= 1'b1;
    end

    always_comb begin
        unused_fields = 1'b0;
        for (int i = 0; i < NUM_PAIRS; i++)
            unused_fields = unused_fields ^ (^{live_ctl[i].world, live_ctl[i].lanes, live_ctl[i].level});
    end

    a_r1_quiet_before_barrier: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_barrier |-> bp_hit_vec == '0);

    a_r12_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> bp_hit_vec == '0);

    a_r12_follows_match: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> bp_hit_vec == $past(raw_vec));

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        a_r8_target_silent: assert property (@(posedge clk) disable iff (!rst_n)
            (live_ctl[i].mode == MD_CTX_TGT || live_ctl[i].mode[2:1] == 2'b11) |-> !raw_vec[i]);

        a_r9_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
            (raw_vec[i] && priv_mode && monitor_mode) |->
            (live_ctl[i].mode == MD_ADDR || live_ctl[i].mode == MD_ADDR_LNK));

        a_r7_self_link: assert property (@(posedge clk) disable iff (!rst_n)
            ((live_ctl[i].mode == MD_ADDR_LNK || live_ctl[i].mode == MD_MIS_LNK) &&
             int'(live_ctl[i].link) == i) |-> !raw_vec[i]);
    end
endmodule

bind bkpt_unit bkpt_unit_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .barrier(barrier),
    .priv_mode(priv_mode), .monitor_mode(monitor_mode), .live_ctl(live_ctl),
    .raw_vec(raw_vec), .bp_hit_vec(bp_hit_vec)
);

// File: tb/sim_bkpt_unit.sv
// Self-checking bench: directed cases plus sweeps judged by a reference model.
module sim_bkpt_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic [3:0]  fetch_lanes = '0;
    logic        priv_mode = 1'b0, secure = 1'b0, monitor_mode = 1'b0;
    logic [31:0] ctx_id = '0;
    logic        wr_val_en = 1'b0, wr_ctl_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        barrier = 1'b0;
    logic        bp_hit;
    logic [5:0]  bp_hit_vec;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [31:0] sv_[6], sc_[6], lv_[6], lc_[6];

    always #4 clk = ~clk;

    bkpt_unit u0 (.*);

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic logic [31:0] mk(input int md, input int lk, input int wd,
                                       input int ln, input int lv, input int en);
        return {9'b0, 3'(md), 4'(lk), 2'(wd), 5'b0, 4'(ln), 2'b0, 2'(lv), 1'(en)};
    endfunction

    // Reference model of the active settings, from the requirements.
    function automatic logic [5:0] model(input logic [31:0] a, input logic [3:0] l,
                                         input logic p, input logic s,
                                         input logic [31:0] c, input logic m);
        logic [5:0] r = '0;
        for (int i = 0; i < 6; i++) begin
            logic [2:0] md = lc_[i][22:20];
            logic [1:0] wd = lc_[i][15:14], lvv = lc_[i][2:1];
            logic [3:0] bs = lc_[i][8:5];
            int lk = int'(lc_[i][19:16]);
            logic wok = (wd == 0) || (wd == 1 && !s) || (wd == 2 && s);
            logic pok = (lvv == 3) || (lvv == 1 && p) || (lvv == 2 && !p);
            logic aeq = (lv_[i][31:2] == a[31:2]) && ((bs & l) != 0);
            logic ane = (bs != 0) && !aeq;
            logic ceq = (i >= 4) && (lv_[i] == c);
            logic base = lc_[i][0] && wok && pok;
            logic sup = p && m;
            logic lok = 1'b0;
            if (lk < 6 && lk != i && lk >= 4)
                lok = (lc_[lk][22:20] == 3) && lc_[lk][0] && (lv_[lk] == c);
            case (md)
                0: r[i] = base && aeq;
                1: r[i] = base && aeq && lok;
                2: r[i] = base && ceq && !sup;
                4: r[i] = base && ane && !sup;
                5: r[i] = base && ane && lok && !sup;
                default: r[i] = 1'b0;
            endcase
        end
        return r;
    endfunction

    task automatic chk(input logic [5:0] exp, input string tag);
        n_chk++;
        if (bp_hit_vec !== exp || bp_hit !== (exp != 0)) begin
            n_fail++;
            $display("FAIL %s: actual vec=%b hit=%b expected vec=%b hit=%b",
                     tag, bp_hit_vec, bp_hit, exp, exp != 0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin sv_[i] = 0; sc_[i] = 0; lv_[i] = 0; lc_[i] = 0; end
    endtask

    task automatic wr(input int i, input logic ctl, input logic [31:0] d);
        @(negedge clk);
        wr_idx = 3'(i); wr_data = d; wr_val_en = !ctl; wr_ctl_en = ctl;
        @(negedge clk);
        wr_val_en = 1'b0; wr_ctl_en = 1'b0;
        if (ctl) sc_[i] = (i < 4) ? (d & ~32'h0020_0000) : d;
        else     sv_[i] = d;
    endtask

    task automatic commit();
        @(negedge clk); barrier = 1'b1;
        @(negedge clk); barrier = 1'b0;
        for (int i = 0; i < 6; i++) begin lv_[i] = sv_[i]; lc_[i] = sc_[i]; end
    endtask

    // Present one fetch (optionally with a barrier or without valid), return model value.
    task automatic fetch(input logic [31:0] a, input logic [3:0] l, input logic p,
                         input logic s, input logic [31:0] c, input logic m,
                         input logic v, input logic bar, output logic [5:0] mexp);
        @(negedge clk);
        fetch_addr = a; fetch_lanes = l; priv_mode = p; secure = s;
        ctx_id = c; monitor_mode = m; fetch_valid = v; barrier = bar;
        mexp = v ? model(a, l, p, s, c, m) : 6'b0;
        @(posedge clk); @(negedge clk);
        fetch_valid = 1'b0; barrier = 1'b0;
        if (bar) for (int i = 0; i < 6; i++) begin lv_[i] = sv_[i]; lc_[i] = sc_[i]; end
    endtask

    task automatic f(input logic [31:0] a, input logic [3:0] l, input logic p,
                     input logic s, input logic [31:0] c, input logic m,
                     input logic [5:0] exp, input string tag);
        logic [5:0] me;
        fetch(a, l, p, s, c, m, 1'b1, 1'b0, me);
        chk(exp, tag);
    endtask

    initial begin
        logic [5:0] me;
        do_reset();
        chk(6'b0, "R1 reset outputs");
        f(32'h0, 4'hF, 1, 1, 0, 0, 6'b0, "R1 no hit after reset");

        // R11: staged writes wait for the barrier; barrier cycle uses old settings.
        wr(0, 0, 32'h100); wr(0, 1, mk(0, 0, 0, 15, 3, 1));
        f(32'h100, 4'hF, 0, 0, 0, 0, 6'b0, "R11 no effect before barrier");
        fetch(32'h100, 4'hF, 0, 0, 0, 0, 1'b1, 1'b1, me); chk(6'b0, "R11 fetch in barrier cycle");
        f(32'h100, 4'hF, 0, 0, 0, 0, 6'b000001, "R11 effect after barrier");
        fetch(32'h100, 4'hF, 0, 0, 0, 0, 1'b0, 1'b0, me); chk(6'b0, "R12 no valid no hit");

        // R2: byte lanes and word compare.
        wr(0, 1, mk(0, 0, 0, 1, 3, 1)); commit();
        f(32'h100, 4'b0010, 0, 0, 0, 0, 6'b0, "R2 lane miss");
        f(32'h101, 4'b0001, 0, 0, 0, 0, 6'b000001, "R2 lane hit");
        f(32'h104, 4'b0001, 0, 0, 0, 0, 6'b0, "R2 other word");
        wr(0, 1, mk(0, 0, 0, 0, 3, 1)); commit();
        f(32'h100, 4'hF, 0, 0, 0, 0, 6'b0, "R2 zero select");

        // R4: world and privilege gates.
        wr(0, 1, mk(0, 0, 1, 15, 2, 1)); commit();
        f(32'h100, 4'hF, 0, 0, 0, 0, 6'b000001, "R4 non-secure user");
        f(32'h100, 4'hF, 0, 1, 0, 0, 6'b0, "R4 secure blocked");
        f(32'h100, 4'hF, 1, 0, 0, 0, 6'b0, "R4 privileged blocked");

        // R3 and R9: mismatch and suppression.
        wr(0, 1, 32'h0); wr(1, 0, 32'h200); wr(1, 1, mk(4, 0, 0, 15, 3, 1)); commit();
        f(32'h100, 4'hF, 0, 0, 0, 0, 6'b000010, "R3 mismatch fires");
        f(32'h200, 4'hF, 0, 0, 0, 0, 6'b0, "R3 match quiet");
        f(32'h100, 4'hF, 1, 0, 0, 1, 6'b0, "R9 mismatch suppressed");
        f(32'h100, 4'hF, 1, 0, 0, 0, 6'b000010, "R9 no monitor no suppress");
        wr(0, 1, mk(0, 0, 0, 15, 3, 1)); commit();
        f(32'h100, 4'hF, 1, 0, 0, 1, 6'b000001, "R9 address match kept");

        // R5 and R10: context compare and bit 21 masking.
        do_reset();
        wr(4, 0, 32'hCAFE0001); wr(4, 1, mk(2, 0, 0, 0, 3, 1));
        wr(1, 0, 32'h300); wr(1, 1, mk(2, 0, 0, 15, 3, 1)); commit();
        f(32'h0, 4'hF, 0, 0, 32'hCAFE0001, 0, 6'b010000, "R5 context hit");
        f(32'h0, 4'hF, 0, 0, 32'hCAFE0000, 0, 6'b0, "R5 context miss");
        f(32'h300, 4'hF, 0, 0, 32'h0, 0, 6'b000010, "R10 bit 21 forced zero");

        // R6: linked pairs sharing one target.
        do_reset();
        wr(4, 0, 32'h55); wr(4, 1, mk(3, 0, 2, 15, 1, 1));
        wr(0, 0, 32'h400); wr(0, 1, mk(1, 4, 0, 15, 3, 1));
        wr(2, 0, 32'h400); wr(2, 1, mk(1, 4, 0, 15, 3, 1)); commit();
        f(32'h400, 4'hF, 0, 0, 32'h55, 0, 6'b000101, "R6 linked hit shared target");
        f(32'h400, 4'hF, 0, 0, 32'h56, 0, 6'b0, "R6 context miss");
        wr(4, 1, mk(3, 0, 2, 15, 1, 0)); commit();
        f(32'h400, 4'hF, 0, 0, 32'h55, 0, 6'b0, "R6 target disabled");

        // R7 and R8: invalid links and silent modes.
        wr(4, 1, mk(3, 0, 0, 15, 3, 1));
        wr(0, 1, mk(1, 0, 0, 15, 3, 1));
        wr(2, 1, mk(1, 7, 0, 15, 3, 1));
        wr(3, 0, 32'h400); wr(3, 1, mk(1, 1, 0, 15, 3, 1));
        wr(5, 0, 32'h400); wr(5, 1, mk(1, 4, 0, 15, 3, 1)); commit();
        f(32'h400, 4'hF, 0, 0, 32'h55, 0, 6'b100000, "R7 bad links give no hit");
        wr(5, 1, mk(6, 4, 0, 15, 3, 1)); commit();
        f(32'h400, 4'hF, 0, 0, 32'h55, 0, 6'b0, "R8 reserved mode 110");
        wr(5, 1, mk(7, 4, 0, 15, 3, 1)); commit();
        f(32'h400, 4'hF, 0, 0, 32'h55, 0, 6'b0, "R8 reserved mode 111");

        // Sweep of mode, world and privilege fields on a context-capable pair (R4).
        do_reset();
        for (int md = 0; md < 8; md++)
            for (int wd = 0; wd < 4; wd++)
                for (int lvv = 0; lvv < 4; lvv++) begin
                    wr(4, 0, 32'h2000); wr(4, 1, mk(md, 0, wd, 15, lvv, 1)); commit();
                    for (int k = 0; k < 16; k++) begin
                        fetch(k[0] ? 32'h2000 : 32'h3000, 4'hF, k[1], k[2],
                              k[3] ? 32'h2000 : 32'h77, k[1] & k[0], 1'b1, 1'b0, me);
                        chk(me, "R4 sweep");
                    end
                end

        // Randomized link sweep across all pairs (R6, R7, R9).
        do_reset();
        for (int r = 0; r < 250; r++) begin
            for (int i = 0; i < 6; i++) begin
                logic [31:0] pool[4] = '{32'h1000, 32'h1004, 32'hA5, 32'h5A};
                wr(i, 0, pool[$urandom % 4]);
                wr(i, 1, mk($urandom % 8, $urandom % 8, $urandom % 4, $urandom % 16,
                            $urandom % 4, ($urandom % 4) != 0));
            end
            commit();
            for (int k = 0; k < 8; k++) begin
                logic [31:0] ap[3] = '{32'h1000, 32'h1004, 32'h1008};
                logic [31:0] cp[3] = '{32'hA5, 32'h5A, 32'h1000};
                fetch(ap[$urandom % 3] | 32'($urandom % 4), 4'($urandom), 1'($urandom),
                      1'($urandom), cp[$urandom % 3], 1'($urandom), 1'b1, 1'b0, me);
                chk(me, "R6 random link sweep");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule